// File: doc/BRIEF.md
# Paired Two-Stage DMA Channel Arbiter

This block picks one of four DMA channel requesters and grants it exclusive use of a shared resource. The channels form two pairs, {0,1} and {2,3}. A first stage resolves the contest inside each pair. A second stage then chooses between the two pair winners. Each of the three contests has its own setting. It either always favours one chosen member or alternates between the two members in round-robin order.

The grant is registered. It is presented as a one-hot vector together with a binary channel index. It stays in place until the granted channel pulses `done_i`. The grant is released on the edge that follows that pulse, and a fresh contest is resolved one cycle later. The round-robin state moves only when a grant is issued. In each contest, the member that lost the last grant is favoured the next time both members compete.

Top module: `dma_pair_arbiter`

## Requirements
- R1: `gnt_o` is zero or one-hot at all times. When it is non-zero, `gnt_idx_o` is the number of its set bit. When it is zero, `gnt_idx_o` is 0. Both are zero out of reset.
- R2: When there is no grant and at least one request is sampled at a rising edge, a grant to one requesting channel appears at that same edge.
- R3: Pair setting fields: `cfg_i[0]` is the pair {0,1} mode and `cfg_i[2]` is the pair {2,3} mode, where 1 means round-robin and 0 means fixed. `cfg_i[1]` and `cfg_i[3]` are the fixed-mode favourites, where 0 means the lower channel and 1 means the upper channel. In fixed mode, when both members of a pair request, the favourite wins.
- R4: In round-robin mode, a pair whose members both request grants the member that is not the one last granted from that pair. After reset, the lower member is favoured.
- R5: Between pairs, `cfg_i[4]` is the mode (1 means round-robin) and `cfg_i[5]` is the fixed favourite (0 means pair {0,1}). In fixed mode, when both pairs have a requester, the favourite pair wins.
- R6: In round-robin mode between pairs, when both pairs have a requester, the pair that was not last granted wins. After reset, pair {0,1} is favoured.
- R7: While a grant is held and `done_i` is low, `gnt_o` and `gnt_idx_o` stay unchanged, whatever happens to the requests.
- R8: When `done_i` is high while a grant is held, the grant is cleared at that edge. The next grant can appear no earlier than the following edge.
- R9: With no requests, no grant is issued and the round-robin state is unchanged, so the order resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 4 | Channel request lines, bit n for channel n |
| cfg_i | input | 6 | Priority settings (fields in R3 and R5) |
| done_i | input | 1 | Granted channel finished; releases the grant |
| gnt_o | output | 4 | One-hot grant |
| gnt_idx_o | output | 2 | Index of the granted channel |

## Verification
The release of a grant through `done_i` and new requests from the other channels can fall in the same cycle. The pending round-robin decision must then survive the gap cycle. The bench provokes this by keeping all four requests high through the `done_i` pulse. It judges the result by requiring one idle cycle and then the grant to the channel that the pointer history predicts. It also sets up an idle stretch between round-robin grants, which must leave that history unchanged.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int NUM_CH   = 4;
    localparam int PAIR_W   = 2;
    localparam int NUM_PAIR = NUM_CH / PAIR_W;
    localparam int IDX_W    = $clog2(NUM_CH);

    // One contest: rr = 1 selects round-robin, fav is the fixed-mode favourite
    typedef struct packed {
        logic fav;
        logic rr;
    } lvl_cfg_t;

    // Bit layout: [5:4] between pairs, [3:2] pair {2,3}, [1:0] pair {0,1}
    typedef struct packed {
        lvl_cfg_t                top;
        lvl_cfg_t [NUM_PAIR-1:0] pair;
    } arb_cfg_t;

endpackage

// File: rtl/arb_pair_pick.sv
module arb_pair_pick (
    input  logic [1:0] req_i,
    input  logic       rr_mode_i,
    input  logic       fav_i,
    input  logic       rr_ptr_i,
    output logic       valid_o,
    output logic       sel_o
);

    always_comb begin
        valid_o = |req_i;
        unique case (req_i)
            2'b01:   sel_o = 1'b0;
            2'b10:   sel_o = 1'b1;
            2'b11:   sel_o = rr_mode_i ? rr_ptr_i : fav_i;
            default: sel_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_pair_arbiter.sv
module dma_pair_arbiter
    import dma_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_i,
    input  logic [5:0]        cfg_i,
    input  logic              done_i,
    output logic [NUM_CH-1:0] gnt_o,
    output logic [IDX_W-1:0]  gnt_idx_o
);

    typedef struct packed {
        logic [NUM_CH-1:0]   gnt;
        logic [IDX_W-1:0]    idx;
        logic [NUM_PAIR-1:0] pptr;
        logic                tptr;
    } state_t;

    state_t   s_d, s_q;
    arb_cfg_t cfg;

    logic [NUM_PAIR-1:0] pair_vld;
    logic [NUM_PAIR-1:0] pair_sel;
    logic                top_vld;
    logic                top_sel;

    assign cfg = arb_cfg_t'(cfg_i);

    // First stage: one contest per pair
    for (genvar g = 0; g < NUM_PAIR; g++) begin : g_pair
        arb_pair_pick u_pick (
            .req_i     (req_i[g*PAIR_W +: PAIR_W]),
            .rr_mode_i (cfg.pair[g].rr),
            .fav_i     (cfg.pair[g].fav),
            .rr_ptr_i  (s_q.pptr[g]),
            .valid_o   (pair_vld[g]),
            .sel_o     (pair_sel[g])
        );
    end

    // Second stage: between the pair winners
    arb_pair_pick u_top (
        .req_i     (pair_vld),
        .rr_mode_i (cfg.top.rr),
        .fav_i     (cfg.top.fav),
        .rr_ptr_i  (s_q.tptr),
        .valid_o   (top_vld),
        .sel_o     (top_sel)
    );

    always_comb begin
        logic win_mem;
        s_d     = s_q;
        win_mem = pair_sel[top_sel];
        if (s_q.gnt != '0) begin
            if (done_i) begin
                s_d.gnt = '0;
                s_d.idx = '0;
            end
        end else if (top_vld) begin
            s_d.idx           = {top_sel, win_mem};
            s_d.gnt           = NUM_CH'(1) << s_d.idx;
            s_d.pptr[top_sel] = ~win_mem;
            s_d.tptr          = ~top_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign gnt_o     = s_q.gnt;
    assign gnt_idx_o = s_q.idx;

    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    a_r1_index: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0) ? gnt_o[gnt_idx_o] : (gnt_idx_o == '0));

    a_r2_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && $past(gnt_o) == '0) |-> (($past(req_i) & gnt_o) != '0));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && !done_i) |=> ($stable(gnt_o) && $stable(gnt_idx_o)));

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && done_i) |=> (gnt_o == '0));

    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0 && req_i == '0) |=>
            (gnt_o == '0 && $stable(s_q.pptr) && $stable(s_q.tptr)));

endmodule

// File: tb/dma_pair_arbiter_tb.sv
module dma_pair_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic [5:0] cfg = '0;
    logic       done = 1'b0;
    logic [3:0] gnt;
    logic [1:0] gnt_idx;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic [1:0] exp_q[$];
    logic [3:0] prev_gnt = '0;

    always #10 clk = ~clk;

    dma_pair_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .cfg_i(cfg),
        .done_i(done), .gnt_o(gnt), .gnt_idx_o(gnt_idx)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Monitor: every newly issued grant is compared with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && gnt != '0 && prev_gnt == '0) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected grant", {2'b0, gnt}, 6'h0);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                check(gnt == (4'b1 << e) && gnt_idx == e, "R1 R3-R6 grant order",
                      {gnt_idx, gnt}, {e, 4'b1 << e});
            end
        end
        prev_gnt = gnt;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 5000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Driver: push expectation, raise requests, hold, release with done
    task automatic grant_cycle(input logic [3:0] r, input logic [5:0] c,
                               input logic [1:0] e, input string tag);
        logic [3:0] held;
        exp_q.push_back(e);
        cfg = c;
        req = r;
        @(negedge clk);
        check(gnt == (4'b1 << e), {tag, " R2 grant next edge"}, {2'b0, gnt}, {2'b0, 4'b1 << e});
        held = gnt;
        req = '0;
        repeat (2) @(negedge clk);
        check(gnt == held && gnt_idx == e, "R7 held without done", {gnt_idx, gnt}, {e, held});
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        check(gnt == '0 && gnt_idx == '0, "R8 release after done", {gnt_idx, gnt}, 6'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(gnt == '0 && gnt_idx == '0, "R1 reset state", {gnt_idx, gnt}, 6'h0);
        rst_n = 1'b1;
        @(negedge clk);

        grant_cycle(4'b0011, 6'b000000, 2'd0, "R3 pair0 fav low");
        grant_cycle(4'b0011, 6'b000010, 2'd1, "R3 pair0 fav high");
        grant_cycle(4'b1100, 6'b001000, 2'd3, "R3 pair1 fav high");
        grant_cycle(4'b1111, 6'b000000, 2'd0, "R5 top fav pair0");
        grant_cycle(4'b1111, 6'b100000, 2'd2, "R5 top fav pair1");
        grant_cycle(4'b0011, 6'b000001, 2'd1, "R4 pair0 rr a");
        grant_cycle(4'b0011, 6'b000001, 2'd0, "R4 pair0 rr b");
        grant_cycle(4'b0011, 6'b000001, 2'd1, "R4 pair0 rr c");
        grant_cycle(4'b1111, 6'b010101, 2'd3, "R6 all rr a");
        grant_cycle(4'b1111, 6'b010101, 2'd0, "R6 all rr b");
        grant_cycle(4'b1111, 6'b010101, 2'd2, "R6 all rr c");
        grant_cycle(4'b1111, 6'b010101, 2'd1, "R6 all rr d");

        // R9: idle stretch issues nothing and keeps the rotation
        repeat (4) begin
            @(negedge clk);
            check(gnt == '0, "R9 no grant when idle", {2'b0, gnt}, 6'h0);
        end
        exp_q.push_back(2'd3);
        exp_q.push_back(2'd0);
        req = 4'b1111;
        @(negedge clk);
        check(gnt == 4'b1000, "R9 rotation resumed", {2'b0, gnt}, 6'h08);
        // R8: done with requests still pending gives one idle cycle, then regrant
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        check(gnt == '0, "R8 gap with pending requests", {2'b0, gnt}, 6'h0);
        @(negedge clk);
        check(gnt == 4'b0001 && gnt_idx == 2'd0, "R4 R6 regrant after gap",
              {gnt_idx, gnt}, 6'h01);
        req = '0;
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0, "R2 all expected grants seen", 6'(exp_q.size()), 6'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule